// File: doc/BRIEF.md
# Start-up Reset Completion Coordinator

This block drives the power-up phase of a packet-handling controller. A shared 3-bit phase code selects which part of the controller may act; this block responds only to the all-zero code. When the phase code enters that value, the block emits a single-cycle start pulse. The pulse is routed to each of three initialisation sequencers: the DAC, the ADC and the network controller. A sequencer receives it only if its enable input is set.

Each sequencer reports completion through a done flag. The block combines those flags into one completion condition. A target that is not enabled counts as already finished. When the condition rises, the block issues one single-cycle advance pulse, which the surrounding logic uses as the write enable of its phase register. The sequencers are modelled as down-counters, each with its own latency parameter. The waveforms that a real device would need are not part of this block.

Top module: `rst_phase_coord`

## Requirements
- R1: A synchronous, active-high reset clears the start outputs, every done flag and the advance pulse at the next clock edge. It also cancels any initialisation that is in progress.
- R2: The block ignores every phase code other than 3'b000. A clock edge that samples a non-zero code produces no start pulse in the following cycle.
- R3: When an edge samples code 3'b000, and the previous edge sampled a different code or reset was active, the start pulse is high for exactly the next cycle. If the code stays at 3'b000, no further start pulse follows.
- R4: The start output for each target is the common start pulse ANDed with that target's enable. Bit 0 is the DAC, bit 1 the ADC and bit 2 the network controller, on both the enable and start vectors.
- R5: The done flag of an enabled target is low in the cycle after its start pulse. It goes high LAT+1 cycles after the start-pulse cycle, where LAT is that target's latency parameter. It then stays high until the target's next start or a reset.
- R6: A target that is not enabled is not started, and its done flag keeps its previous value for the whole phase.
- R7: The advance pulse is high for exactly one cycle, 2+M cycles after the start-pulse cycle. M is the largest latency among the enabled targets, or 0 if none is enabled. In that cycle every enabled target reports done.
- R8: The advance pulse fires once per phase entry. Done flags left set by an earlier phase cannot make it fire early.
- R9: Leaving 3'b000 and then entering it again starts a new phase, with fresh start pulses and a new advance pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_code | input | 3 | Shared controller phase code; 3'b000 selects this block |
| tgt_en | input | 3 | Per-target enable: bit0 DAC, bit1 ADC, bit2 network controller |
| tgt_start | output | 3 | Per-target one-cycle start pulse |
| tgt_done | output | 3 | Per-target done flag |
| phase_adv | output | 1 | One-cycle pulse that advances the phase register |

## Verification
Every result has a fixed latency, counted from the cycle in which the start pulse is visible (t=0). That cycle follows the first edge that samples 3'b000. Target i reports done from t=LAT_i+1 onward, and the advance pulse is expected at exactly t=2+M. The bench drives inputs on falling edges and samples on falling edges. It predicts each output for every t from 0 to 40 using a bench model of the done flags, and that model also carries stale flags from one phase to the next. Between phases, the bench holds random non-zero codes and checks that nothing starts and no advance pulse appears.

// File: rtl/rst_coord_pkg.sv
package rst_coord_pkg;
  localparam int TGT_N   = 3;
  localparam int STATE_W = 3;
  localparam int TGT_DAC = 0;
  localparam int TGT_ADC = 1;
  localparam int TGT_NET = 2;

  typedef logic [TGT_N-1:0]   tgt_vec_t;
  typedef logic [STATE_W-1:0] phase_t;

  localparam phase_t PHASE_BOOT = '0;

  function automatic int pick_lat(input int idx, input int l_dac, input int l_adc, input int l_net);
    if (idx == TGT_DAC) return l_dac;
    if (idx == TGT_ADC) return l_adc;
    return l_net;
  endfunction
endpackage

// File: rtl/rst_phase_trigger.sv
module rst_phase_trigger
  import rst_coord_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  phase_t   phase_code,
  input  tgt_vec_t tgt_en,
  output logic     start_any,
  output tgt_vec_t tgt_start
);
  logic hit;
  logic seen_q;
  logic fire;

  assign hit  = (phase_code == PHASE_BOOT);
  assign fire = hit & ~seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      start_any <= 1'b0;
      tgt_start <= '0;
    end else begin
      seen_q    <= hit;
      start_any <= fire;
      tgt_start <= fire ? tgt_en : '0;
    end
  end
endmodule

// File: rtl/rst_target_model.sv
module rst_target_model #(
  parameter int LAT   = 4,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
        done   <= 1'b1;
      end else begin
        cnt_q <= cnt_q - LAST;
      end
    end
  end
endmodule

// File: rtl/rst_done_gate.sv
module rst_done_gate
  import rst_coord_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start_any,
  input  tgt_vec_t tgt_en,
  input  tgt_vec_t tgt_done,
  output logic     phase_adv
);
  logic all_ok;
  logic ok_q;
  logic armed_q;
  logic rise;

  // a disabled target is treated as finished
  assign all_ok = &(tgt_done | ~tgt_en);
  assign rise   = armed_q & ~start_any & all_ok & ~ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q      <= 1'b0;
      armed_q   <= 1'b0;
      phase_adv <= 1'b0;
    end else begin
      phase_adv <= rise;
      ok_q      <= start_any ? 1'b0 : all_ok;
      if (start_any)  armed_q <= 1'b1;
      else if (rise)  armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_phase_coord.sv
module rst_phase_coord
  import rst_coord_pkg::*;
#(
  parameter int DAC_CYCLES = 5,
  parameter int ADC_CYCLES = 9,
  parameter int NET_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   phase_code,
  input  logic [2:0]   tgt_en,
  output logic [2:0]   tgt_start,
  output logic [2:0]   tgt_done,
  output logic         phase_adv
);
  localparam int MAX_AB = (DAC_CYCLES > ADC_CYCLES) ? DAC_CYCLES : ADC_CYCLES;
  localparam int MAX_C  = (MAX_AB > NET_CYCLES) ? MAX_AB : NET_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic start_any;

  rst_phase_trigger u_trig (
    .clk        (clk),
    .rst        (rst),
    .phase_code (phase_code),
    .tgt_en     (tgt_en),
    .start_any  (start_any),
    .tgt_start  (tgt_start)
  );

  for (genvar i = 0; i < TGT_N; i++) begin : g_tgt
    localparam int LAT_I = pick_lat(i, DAC_CYCLES, ADC_CYCLES, NET_CYCLES);
    rst_target_model #(.LAT(LAT_I), .CNT_W(CNT_W)) u_model (
      .clk   (clk),
      .rst   (rst),
      .start (tgt_start[i]),
      .done  (tgt_done[i])
    );
  end

  rst_done_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .start_any (start_any),
    .tgt_en    (tgt_en),
    .tgt_done  (tgt_done),
    .phase_adv (phase_adv)
  );
endmodule

// File: rtl/rst_phase_coord_chk.sv
module rst_phase_coord_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] phase_code,
  input logic [2:0] tgt_en,
  input logic [2:0] tgt_start,
  input logic [2:0] tgt_done,
  input logic       phase_adv
);
  // R2
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_code != 3'b000) |=> (tgt_start == 3'b000));

  // R3
  single_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_start != 3'b000) |=> (tgt_start == 3'b000));

  // R4
  gated_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((tgt_start & ~tgt_en) == 3'b000));

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_start != 3'b000) |=> ((tgt_done & $past(tgt_start)) == 3'b000));

  // R7
  adv_width_chk: assert property (@(posedge clk) disable iff (rst)
    phase_adv |=> !phase_adv);

  // R7
  adv_complete_chk: assert property (@(posedge clk) disable iff (rst)
    phase_adv |-> ((tgt_done | ~tgt_en) == 3'b111));

  // R8
  adv_not_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_start != 3'b000) |=> !phase_adv);
endmodule

bind rst_phase_coord rst_phase_coord_chk u_chk (.*);

// File: tb/sim_rst_phase_coord.sv
`timescale 1ns/1ps
module sim_rst_phase_coord;
  localparam int L_DAC = 5;
  localparam int L_ADC = 9;
  localparam int L_NET = 3;
  localparam int WIN   = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] phase_code = 3'b010;
  logic [2:0] tgt_en = 3'b000;
  logic [2:0] tgt_start;
  logic [2:0] tgt_done;
  logic       phase_adv;

  int total = 0;
  int bad   = 0;
  logic [2:0] done_m = 3'b000;

  always #2.5 clk = ~clk;

  rst_phase_coord #(.DAC_CYCLES(L_DAC), .ADC_CYCLES(L_ADC), .NET_CYCLES(L_NET)) u0 (
    .clk(clk), .rst(rst), .phase_code(phase_code), .tgt_en(tgt_en),
    .tgt_start(tgt_start), .tgt_done(tgt_done), .phase_adv(phase_adv)
  );

  function automatic int lat_of(input int i);
    return (i == 0) ? L_DAC : (i == 1) ? L_ADC : L_NET;
  endfunction

  function automatic int adv_at(input logic [2:0] en);
    int m = 0;
    for (int i = 0; i < 3; i++) if (en[i] && lat_of(i) > m) m = lat_of(i);
    return 2 + m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      phase_code = 3'($urandom_range(1, 7));
      chk("R2 no start on non-zero code", {29'd0, tgt_start}, 32'd0);
      chk("R2 no advance on non-zero code", {31'd0, phase_adv}, 32'd0);
    end
    @(negedge clk);
  endtask

  task automatic run_phase(input logic [2:0] en);
    int ex;
    logic [2:0] dexp;
    ex = adv_at(en);
    tgt_en = en;
    @(negedge clk);
    phase_code = 3'b000;
    @(negedge clk);
    chk("R4 R9 gated start at t0", {29'd0, tgt_start}, {29'd0, en});
    chk("R8 no advance at t0", {31'd0, phase_adv}, 32'd0);
    for (int t = 1; t <= WIN; t++) begin
      @(negedge clk);
      chk("R3 start lasts one cycle", {29'd0, tgt_start}, 32'd0);
      for (int i = 0; i < 3; i++)
        dexp[i] = en[i] ? (t >= lat_of(i) + 1) : done_m[i];
      chk("R5 R6 done flags", {29'd0, tgt_done}, {29'd0, dexp});
      chk("R7 R8 advance timing", {31'd0, phase_adv}, {31'd0, (t == ex)});
    end
    done_m = done_m | en;
    idle_gap(4);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset start", {29'd0, tgt_start}, 32'd0);
    chk("R1 reset done", {29'd0, tgt_done}, 32'd0);
    chk("R1 reset advance", {31'd0, phase_adv}, 32'd0);
    rst = 1'b0;
    idle_gap(3);

    run_phase(3'b000);
    run_phase(3'b111);
    run_phase(3'b010);
    run_phase(3'b101);

    tgt_en = 3'b111;
    @(negedge clk);
    phase_code = 3'b000;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    phase_code = 3'b011;
    @(negedge clk);
    chk("R1 mid-phase reset start", {29'd0, tgt_start}, 32'd0);
    chk("R1 mid-phase reset done", {29'd0, tgt_done}, 32'd0);
    chk("R1 mid-phase reset advance", {31'd0, phase_adv}, 32'd0);
    done_m = 3'b000;
    rst = 1'b0;
    idle_gap(2);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R1 no late advance after reset", {31'd0, phase_adv}, 32'd0);
    end

    for (int r = 0; r < 12; r++) run_phase(3'($urandom_range(0, 7)));
    run_phase(3'b001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule